// File: doc/BRIEF.md
# Reset Cause Control Register

This block is a single 32-bit control and status register that tells software why the system last came out of reset and lets software ask for a soft reset. It sits at one byte address on a simple register bus. Bus writes take effect at the clock edge. Reads are combinational. Any address other than the register's own reads as zero and has no effect when written.

Five bits are implemented, at positions 31 to 27. Bit 31 (power-on cause), bit 28 (button power-on cause) and bit 27 (button external-reset cause) are cleared by writing 1. Bit 30 (soft power-on) and bit 29 (soft external reset) are set by writing 1, and a write of 0 leaves them unchanged. Writing 1 to either soft bit sends a one-cycle pulse on `sys_rst_req` to the reset generator. A saturating count of system resets decides whether a reset is treated as the first one after power-on. A soft power-on write sets that count back to zero. A soft external-reset write leaves the count as it is.

A small state machine controls the register. `ST_HOLD` is entered from any state whenever `rst_n` is sampled low, and after `por_n`. The transition `ST_HOLD -> ST_RUN` (reset release) happens on the first edge with `rst_n` high. On that edge the count is incremented, and if the count was zero the register is loaded with only bit 31 set. The transition `ST_RUN -> ST_PULSE` (soft trigger) happens on an accepted write that has bit 30 or bit 29 set. `ST_PULSE -> ST_RUN` (pulse end) always follows one cycle later. `ST_RUN` loops on itself when there is no trigger.

Top module: `rstcause_reg`

## Requirements
- R1: Only bits 31..27 exist. Bits 26..0 always read as 0 and ignore writes.
- R2: Writing 1 to bit 31, 28 or 27 clears that bit. Writing 0 to it leaves it unchanged.
- R3: Writing 1 to bit 30 or 29 sets that bit. Writing 0 to it leaves it unchanged.
- R4: A write with bit 30 = 1 sets the reset count to zero and requests a system reset. The next reset release then loads the register with 0x80000000.
- R5: A write with bit 29 = 1 (and bit 30 = 0) requests a system reset and does not change the count.
- R6: `sys_rst_req` is high for exactly the one cycle after the edge that accepted the triggering write. Writes during that pulse cycle are ignored.
- R7: On reset release, if the count is zero the register becomes exactly 0x80000000. Otherwise the register keeps its value. In both cases the count increments.
- R8: The count saturates at 2^CNT_W-1 and never wraps back to zero, so repeated resets never look like a power-on.
- R9: Only byte address REG_ADDR (default 0xF024) is decoded. Address 0xF020 and all other addresses read 0 and ignore writes.
- R10: `por_n` low clears the register and the count. While `rst_n` is low, writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| rst_n | input | 1 | System reset, sampled on the clock, active low |
| bus_addr | input | AW | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The embedded assertions check on every cycle that:
- the unimplemented read bits are zero;
- the reset request never lasts longer than one cycle, and always follows an accepted soft-trigger write;
- a release with a zero count loads the power-on value;
- the count only moves downward on a clear, and stays at its maximum once saturated.

Only the bench scenarios can show the effects that depend on history:
- whether the count was kept or cleared by a soft write, which appears only at a later reset release;
- that the count does not wrap after many resets;
- that writes made during the hold state or the pulse cycle have no effect.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;
    localparam int          DATA_W       = 32;
    localparam logic [31:0] CAUSE_IMPL   = 32'hF800_0000;
    localparam logic [31:0] CAUSE_W1C    = 32'h9800_0000;
    localparam logic [31:0] CAUSE_W1S    = 32'h6000_0000;
    localparam logic [31:0] CAUSE_PWRON  = 32'h8000_0000;
    localparam int          BIT_SOFT_PWR = 30;
    localparam int          BIT_SOFT_EXT = 29;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_RUN   = 2'd1,
        ST_PULSE = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/rstcause_decode.sv
module rstcause_decode #(
    parameter int             AW       = 16,
    parameter logic [AW-1:0]  REG_ADDR = 16'hF024
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    always_comb hit = (addr == REG_ADDR);
endmodule

// File: rtl/rstcause_counter.sv
module rstcause_counter #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic clr,
    input  logic inc,
    output logic cnt_zero
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb cnt_zero = (cnt_q == '0);

    // R8
    cnt_monotonic_chk: assert property (@(posedge clk) disable iff (!por_n)
        !clr |=> cnt_q >= $past(cnt_q));

    // R8
    cnt_saturate_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cnt_q == CNT_MAX && !clr) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/rstcause_reg.sv
module rstcause_reg
    import rstcause_pkg::*;
#(
    parameter int            AW       = 16,
    parameter logic [AW-1:0] REG_ADDR = 16'hF024,
    parameter int            CNT_W    = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sys_rst_req
);
    ctl_state_e        state_q, state_d;
    logic [DATA_W-1:0] cause_q;
    logic [DATA_W-1:0] wv;
    logic              hit, accept, trig_pwr, trig_ext, leave_hold, cnt_zero;

    rstcause_decode #(.AW(AW), .REG_ADDR(REG_ADDR)) u_decode (
        .addr (bus_addr),
        .hit  (hit)
    );

    // Writes land only while running, outside the pulse cycle.
    always_comb begin
        accept     = (state_q == ST_RUN) && rst_n && bus_wr && hit;
        wv         = bus_wdata & CAUSE_IMPL;
        trig_pwr   = accept && wv[BIT_SOFT_PWR];
        trig_ext   = accept && wv[BIT_SOFT_EXT];
        leave_hold = (state_q == ST_HOLD) && rst_n;
    end

    rstcause_counter #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .por_n    (por_n),
        .clr      (trig_pwr),
        .inc      (leave_hold),
        .cnt_zero (cnt_zero)
    );

    always_comb begin
        state_d = state_q;
        if (!rst_n) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD:  state_d = ST_RUN;
                ST_RUN:   state_d = (trig_pwr || trig_ext) ? ST_PULSE : ST_RUN;
                ST_PULSE: state_d = ST_RUN;
                default:  state_d = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cause_q <= '0;
        end else if (leave_hold && cnt_zero) begin
            cause_q <= CAUSE_PWRON;
        end else if (accept) begin
            cause_q <= (cause_q & ~(wv & CAUSE_W1C)) | (wv & CAUSE_W1S);
        end
    end

    always_comb begin
        sys_rst_req = (state_q == ST_PULSE);
        bus_rdata   = hit ? cause_q : '0;
    end

    // R1
    impl_bits_chk: assert property (@(posedge clk) disable iff (!por_n)
        (bus_rdata & ~CAUSE_IMPL) == '0);

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst_req |=> !sys_rst_req);

    // R6
    pulse_follows_write_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst_req) |-> ($past(bus_wr) && $past(hit)));

    // R7
    pwron_load_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_HOLD && rst_n && cnt_zero) |=> cause_q == CAUSE_PWRON);

    // R10
    hold_no_write_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_HOLD && !rst_n) |=> $stable(cause_q));
endmodule

// File: tb/rstcause_reg_tb.sv
module rstcause_reg_tb;
    localparam int          AW   = 16;
    localparam logic [15:0] A_HI = 16'hF024;
    localparam logic [15:0] A_LO = 16'hF020;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_addr = 16'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        sys_rst_req;

    int total = 0, bad = 0;
    bit done = 0;

    // Behavioural reference: 0 hold, 1 run, 2 pulse
    int          m_st  = 0;
    int          m_cnt = 0;
    logic [31:0] m_cause = 32'h0;

    always #2 clk = ~clk;

    rstcause_reg u_dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sys_rst_req(sys_rst_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk or negedge por_n) begin
        logic [31:0] v;
        if (!por_n) begin
            m_st = 0; m_cnt = 0; m_cause = 32'h0;
        end else if (!rst_n) begin
            m_st = 0;
        end else if (m_st == 0) begin
            if (m_cnt == 0) m_cause = 32'h8000_0000;
            if (m_cnt < 15) m_cnt++;
            m_st = 1;
        end else if (m_st == 2) begin
            m_st = 1;
        end else if (bus_wr && bus_addr == A_HI) begin
            v = bus_wdata & 32'hF800_0000;
            m_cause = (m_cause & ~(v & 32'h9800_0000)) | (v & 32'h6000_0000);
            if (v[30]) begin m_cnt = 0; m_st = 2; end
            else if (v[29]) m_st = 2;
        end
    end

    // Per-cycle comparison against the model (R1, R9, R6)
    always @(posedge clk) begin
        #1;
        if (por_n && !done) begin
            check("R9 cycle rdata", bus_rdata, (bus_addr == A_HI) ? m_cause : 32'h0);
            check("R6 cycle req", {31'h0, sys_rst_req}, {31'h0, m_st == 2});
        end
    end

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0; bus_addr = A_HI; bus_wdata = 32'h0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); bus_addr = a; #1;
        check(tag, bus_rdata, exp);
        bus_addr = A_HI;
    endtask

    task automatic sysreset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
    endtask

    initial begin
        bus_addr = A_HI;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        check("R10 reset state", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(A_HI, 32'h8000_0000, "R7 power-on load");

        wr(A_HI, 32'hFFFF_FFFF);
        check("R4 soft power-on pulse", {31'h0, sys_rst_req}, 32'h1);
        @(negedge clk);
        check("R6 pulse one cycle", {31'h0, sys_rst_req}, 32'h0);
        rd(A_HI, 32'h6000_0000, "R2 R3 R1 mixed write");

        wr(A_HI, 32'h0);
        check("R3 zero write no pulse", {31'h0, sys_rst_req}, 32'h0);
        rd(A_HI, 32'h6000_0000, "R3 zero keeps set bits");

        wr(A_LO, 32'hFFFF_FFFF);
        check("R9 lower word no pulse", {31'h0, sys_rst_req}, 32'h0);
        rd(A_LO, 32'h0, "R9 lower word reads zero");
        rd(A_HI, 32'h6000_0000, "R9 lower write ignored");

        sysreset();
        rd(A_HI, 32'h8000_0000, "R4 zero count reloads power-on");

        wr(A_HI, 32'h2000_0000);
        check("R5 soft external pulse", {31'h0, sys_rst_req}, 32'h1);
        sysreset();
        rd(A_HI, 32'hA000_0000, "R5 count kept, value kept");

        wr(A_HI, 32'h8000_0000);
        rd(A_HI, 32'h2000_0000, "R2 clear power-on bit");

        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); bus_wr = 1'b1; bus_wdata = 32'h4000_0000;
        @(negedge clk); bus_wr = 1'b0; bus_wdata = 32'h0; rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(A_HI, 32'h2000_0000, "R10 write in hold ignored");

        @(negedge clk); bus_wr = 1'b1; bus_wdata = 32'h2000_0000;
        @(negedge clk); bus_wdata = 32'h4000_0000;
        @(negedge clk); bus_wr = 1'b0; bus_wdata = 32'h0;
        check("R6 no second pulse", {31'h0, sys_rst_req}, 32'h0);
        rd(A_HI, 32'h2000_0000, "R6 write in pulse ignored");

        for (int i = 0; i < 16; i++) sysreset();
        rd(A_HI, 32'h2000_0000, "R8 count saturates");

        wr(A_HI, 32'h4000_0000);
        rd(A_HI, 32'h6000_0000, "R3 soft power-on set");
        sysreset();
        rd(A_HI, 32'h8000_0000, "R4 clear then reload");
        rd(16'h0000, 32'h0, "R9 other address");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule